// File: doc/BRIEF.md
# ATM Cell Transmit Port with Header Check Insertion

This block carries ATM cells from a system-clock domain to a line-side framer that runs on its own byte clock. The system side pushes each cell a byte at a time through a valid/ready interface into an asynchronous FIFO. The line side takes the cell back out a byte at a time, and only when the framer acknowledges the transfer. Between the fourth and fifth header bytes the block inserts a header check byte that it computes on the fly. No storage slot is kept for this byte.

The internal cell carries 52 bytes in the plain case. Extra switch-specific header words can stretch it to 56, 60 or 64 bytes, chosen by a two-bit size code. The line-side cell is always one byte longer than the internal one, because it also carries the check byte. The framer can open gaps for its own overhead in two ways. It can drop the acknowledge while the line clock keeps running, or it can stop the line clock for a while. Either way the block holds its output until the next acknowledged edge.

Top module: `atm_cell_tx_port`

## Requirements
- R1: After reset the FIFO is empty, `wr_ready` is 1, and `line_valid` and `line_soc` are 0.
- R2: The size code `cell_size` selects the internal cell length: 0 gives 52 bytes, 1 gives 56, 2 gives 60 and 3 gives 64. This is the number of bytes the line side takes from the FIFO for each cell.
- R3: Each line cell is one byte longer than the internal cell. Line bytes 1 to 4 are internal bytes 1 to 4, line byte 5 is the check byte, and line bytes 6 onward are internal bytes 5 onward, in the order they were written.
- R4: The check byte is a CRC-8 with generator x^8+x^2+x+1 (0x07). It starts from 0, takes each of the four header bytes most significant bit first, and is then XORed with 0x55. For the header 00 00 00 01 it is 0x52.
- R5: A byte moves on a rising `line_clk` edge when `line_valid` and `line_ack` are both 1. While `line_ack` is 0 nothing moves, and `line_data`, `line_soc` and `line_valid` hold their values.
- R6: `line_soc` is 1 with the first line byte of each cell and 0 with every other byte.
- R7: The line side starts a cell only once the whole internal cell is in the FIFO. A partly written cell keeps `line_valid` at 0.
- R8: `cell_size` is sampled when a cell starts. A change made during a cell takes effect from the next cell.
- R9: The FIFO holds 2^AW bytes (128 by default). `wr_ready` drops to 0 when it is full, and no byte that was accepted is lost.
- R10: The line side works correctly when `line_clk` edges are missing for any stretch of time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System-side clock |
| sys_rst_n | input | 1 | System-side reset, active low |
| wr_data | input | 8 | Cell byte from the system side |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | FIFO can accept a byte |
| line_clk | input | 1 | Line byte clock, which may be gated |
| line_rst_n | input | 1 | Line-side reset, active low |
| cell_size | input | 2 | Internal cell length code (52/56/60/64) |
| line_ack | input | 1 | Framer accepts the presented byte |
| line_data | output | 8 | Byte presented to the framer |
| line_valid | output | 1 | A cell byte is presented |
| line_soc | output | 1 | Presented byte is the first of a cell |

## Verification
The bench runs every size code, with a random acknowledge and a randomly gated line clock, against a scoreboard of expected line bytes. A wrong length or a misplaced check byte would show up as a slip in the byte order or the start strobe. A bad CRC would fail the known 0x52 header. A change of size code during a cell must not shorten or lengthen that cell, and a half-written cell must never start to leave the block. With the acknowledge held low the FIFO has to fill to exactly its depth before `wr_ready` drops. Stalls are checked cycle by cycle for a held output, which catches a design that advances a pointer or the check byte without an acknowledge.

// File: rtl/atm_cell_tx_port.sv
module atm_cell_tx_port #(
  parameter int AW = 7
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       line_clk,
  input  logic       line_rst_n,
  input  logic [1:0] cell_size,
  input  logic       line_ack,
  output logic [7:0] line_data,
  output logic       line_valid,
  output logic       line_soc
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [6:0] HEC_POS = 7'd4;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  logic [7:0] mem [DEPTH];

  logic [AW:0] wr_bin, wr_gray, rd_g_s1, rd_g_s2;
  logic [AW:0] rd_bin, rd_gray, wr_g_s1, wr_g_s2;

  wire [AW:0] fill_w = wr_bin - from_gray(rd_g_s2);
  wire        wr_go  = wr_valid && wr_ready;
  assign wr_ready = (fill_w != DEPTH_V);

  always_ff @(posedge sys_clk) if (wr_go) mem[wr_bin[AW-1:0]] <= wr_data;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      rd_g_s1 <= '0;
      rd_g_s2 <= '0;
    end else begin
      rd_g_s1 <= rd_gray;
      rd_g_s2 <= rd_g_s1;
      if (wr_go) begin
        wr_bin  <= wr_bin + 1'b1;
        wr_gray <= to_gray(wr_bin + 1'b1);
      end
    end
  end

  logic       active;
  logic [6:0] pos, last_pos;
  logic [7:0] crc;

  wire [AW:0] fill_r  = from_gray(wr_g_s2) - rd_bin;
  wire [6:0]  len_sel = 7'd52 + {3'b000, cell_size, 2'b00};
  wire        start   = !active && (fill_r >= (AW+1)'(len_sel));
  wire        xfer    = active && line_ack;
  wire [7:0]  mem_rd  = mem[rd_bin[AW-1:0]];

  assign line_valid = active;
  assign line_soc   = active && (pos == 7'd0);
  assign line_data  = (pos == HEC_POS) ? (crc ^ 8'h55) : mem_rd;

  always_ff @(posedge line_clk or negedge line_rst_n) begin
    if (!line_rst_n) begin
      wr_g_s1  <= '0;
      wr_g_s2  <= '0;
      rd_bin   <= '0;
      rd_gray  <= '0;
      active   <= 1'b0;
      pos      <= '0;
      last_pos <= 7'd52;
      crc      <= '0;
    end else begin
      wr_g_s1 <= wr_gray;
      wr_g_s2 <= wr_g_s1;
      if (start) begin
        active   <= 1'b1;
        pos      <= '0;
        last_pos <= len_sel;
      end else if (xfer) begin
        if (pos != HEC_POS) begin
          rd_bin  <= rd_bin + 1'b1;
          rd_gray <= to_gray(rd_bin + 1'b1);
        end
        if (pos < HEC_POS) crc <= crc8_step((pos == 7'd0) ? 8'h00 : crc, mem_rd);
        if (pos == last_pos) active <= 1'b0;
        pos <= pos + 1'b1;
      end
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    fill_w <= DEPTH_V);

  // R5
  ack_hold_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (line_valid && !line_ack) |=> (line_valid && $stable(line_data) && $stable(line_soc)));

  // R6
  soc_first_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    $rose(line_valid) |-> line_soc);

  // R7
  no_underrun_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (line_valid && pos != HEC_POS) |-> (fill_r != '0));

  // R8
  size_latch_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (line_valid && !line_soc) |-> $stable(last_pos));

endmodule

// File: tb/atm_cell_tx_port_tb_top.sv
`timescale 1ns/1ps
module atm_cell_tx_port_tb_top;
  logic sys_clk = 0, line_clk = 0;
  logic sys_rst_n = 0, line_rst_n = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, line_ack = 0;
  logic [1:0] cell_size = 0;
  logic wr_ready, line_valid, line_soc;
  logic [7:0] line_data;

  atm_cell_tx_port dut_i (.*);

  int checks = 0, errors = 0, total_wr = 0, cells_rx = 0, rx_pos = 0;
  int ack_mode = 0;
  bit gate_rand = 0, stalled = 0, hold_s = 0;
  logic [7:0] hold_d, last_hec;
  logic [15:0] lfsr = 16'hACE1, glfsr = 16'h1D2B;
  logic [8:0] exp_q [$];

  always #2.5 sys_clk = ~sys_clk;

  initial forever begin
    glfsr = {glfsr[14:0], glfsr[15] ^ glfsr[13] ^ glfsr[12] ^ glfsr[10]};
    if (!gate_rand || glfsr[0] || glfsr[2]) begin
      #3.5 line_clk = 1;
      #3.5 line_clk = 0;
    end else #7;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [7:0] h0, h1, h2, h3);
    logic [31:0] w;
    logic [7:0] c;
    w = {h0, h1, h2, h3};
    c = 0;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ w[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  // monitor / scoreboard
  always @(negedge line_clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (stalled) // R5
      check(line_valid && line_data == hold_d && line_soc == hold_s, "R5 hold",
            {line_valid, line_soc, line_data}, {1'b1, hold_s, hold_d});
    line_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
    stalled = line_valid && !line_ack;
    hold_d = line_data;
    hold_s = line_soc;
    if (line_valid && line_ack) begin
      if (exp_q.size() == 0) check(0, "R3 extra byte", line_data, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(line_data == e[7:0], "R3 data", line_data, e[7:0]);
        check(line_soc == e[8], "R6 soc", line_soc, e[8]);
      end
      if (line_soc) begin rx_pos = 0; cells_rx++; end
      if (rx_pos == 4) last_hec = line_data;
      rx_pos++;
    end
  end

  task automatic send_cell(input int code, input int seed, input int pause_at);
    logic [7:0] cb [64];
    int len;
    len = 52 + 4 * code;
    for (int k = 0; k < len; k++) cb[k] = 8'(seed * 37 + k * 13 + 5);
    if (seed == 0) begin cb[0] = 0; cb[1] = 0; cb[2] = 0; cb[3] = 1; end
    for (int k = 0; k < 4; k++) exp_q.push_back({k == 0, cb[k]});
    exp_q.push_back({1'b0, hec_of(cb[0], cb[1], cb[2], cb[3])});
    for (int k = 4; k < len; k++) exp_q.push_back({1'b0, cb[k]});
    for (int k = 0; k < len; k++) begin
      if (k == pause_at) begin
        @(negedge sys_clk) wr_valid = 0;
        for (int j = 0; j < 40; j++) begin
          @(negedge line_clk);
          // R7
          check(!line_valid, "R7 partial cell", line_valid, 0);
        end
      end
      @(negedge sys_clk);
      wr_valid = 1;
      wr_data = cb[k];
      while (!wr_ready) @(negedge sys_clk);
      total_wr++;
    end
    @(negedge sys_clk) wr_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || line_valid) @(negedge sys_clk);
    repeat (20) @(negedge sys_clk);
  endtask

  initial begin
    int t;
    repeat (10) @(negedge sys_clk);
    sys_rst_n = 1;
    line_rst_n = 1;
    @(negedge sys_clk);
    // R1
    check(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    check(line_valid == 0 && line_soc == 0, "R1 line idle", {line_valid, line_soc}, 0);

    ack_mode = 0;
    cell_size = 0;
    send_cell(0, 0, -1);
    drain();
    // R4
    check(last_hec == 8'h52, "R4 known HEC", last_hec, 8'h52);

    // R2, R3, R10: each size code, random ack, gated line clock
    ack_mode = 1;
    gate_rand = 1;
    for (int code = 0; code < 4; code++) begin
      cell_size = 2'(code);
      send_cell(code, code * 2 + 1, -1);
      send_cell(code, code * 2 + 2, -1);
      drain();
    end
    // R10
    check(cells_rx == 9, "R10 cells received", cells_rx, 9);

    // R7
    cell_size = 0;
    send_cell(0, 21, 30);
    drain();

    // R8: change size code while a cell is in flight
    ack_mode = 1;
    cell_size = 0;
    send_cell(0, 31, -1);
    while (!line_soc) @(negedge sys_clk);
    cell_size = 1;
    send_cell(1, 32, -1);
    drain();
    check(exp_q.size() == 0, "R8 lengths", exp_q.size(), 0);

    // R9: fill the FIFO with the acknowledge held low
    ack_mode = 2;
    cell_size = 0;
    t = total_wr;
    fork
      begin send_cell(0, 41, -1); send_cell(0, 42, -1); send_cell(0, 43, -1); end
    join_none
    do @(negedge sys_clk); while (wr_ready);
    check(total_wr - t == 128, "R9 full level", total_wr - t, 128);
    ack_mode = 1;
    wait fork;
    drain();
    // R9
    check(exp_q.size() == 0, "R9 no loss", exp_q.size(), 0);
    check(cells_rx == 15, "R2 cell count", cells_rx, 15);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule